// File: doc/BRIEF.md
# Two-Channel Serial Audio Output Formatter

This block takes left/right PCM sample pairs (24-bit two's complement) from an upstream audio decoder and sends them out on a shared bit clock, word-select line and serial data line. It also generates an oversampled master clock for an external DAC. The master clock is derived from the system clock by a fixed integer divider. The bit clock runs at 64 times the sample rate, so each channel owns 32 bit slots per frame. Slots that carry no sample bits are driven low.

One pair can wait in a holding register, which fills through a valid/ready handshake. The formatter takes a pair from that register only at a frame boundary. If no pair is waiting, the previous pair is sent again and an underrun flag is raised.

The following settings are sampled once per frame, at the frame boundary: framing (I2S or right-justified), word length (16, 18, 20 or 22 bits), master-clock ratio (256 or 384 times the sample rate), and the two channel volumes. Muting is also decided at that point, either from the mute input or from an error flag seen during the previous frame.

Top module: `audio_serial_tx`

## Requirements
- R1: `mclk_o` has a period of 2×`MCLK_HALF_DIV` system cycles. One bit-clock period lasts 4 `mclk_o` periods when `ratio_i`=0 (256×fs) and 6 when `ratio_i`=1 (384×fs). `bclk_o` rises together with a falling edge of `mclk_o`. A frame is 64 bit-clock periods.
- R2: `ws_o` is low for slots 0..31 of a frame (left channel) and high for slots 32..63 (right channel). `ws_o` and `sdata_o` change only where `bclk_o` falls.
- R3: With `fmt_i`=0 (I2S), the W-bit word starts MSB first at in-half slot 1, one bit period after the word-select edge. Its LSB is at slot W. Slot 0 and slots above W are low.
- R4: With `fmt_i`=1 (right-justified), the word occupies the last W slots of the half, with its LSB at in-half slot 31. Earlier slots are low.
- R5: `wlen_i` codes 0, 1, 2 and 3 select W = 16, 18, 20 and 22 bits.
- R6: For each channel, an intermediate value floor(sample × vol / 256) is formed as a 24-bit signed quantity, with `vol` an unsigned 8-bit factor. Its top W bits are transmitted.
- R7: If `mute_i` is high at a frame boundary, both channels send all-zero words for that frame.
- R8: If `err_i` is high in any cycle of a frame, including the boundary cycle that ends it, the following frame is muted. Only that one frame is affected.
- R9: `in_ready_o` is high exactly when the holding register is empty. A pair is captured when `in_valid_i` and `in_ready_o` are both high. The register empties at the next frame boundary, and while it is full `in_valid_i` has no effect.
- R10: If the holding register is empty at a frame boundary, the previous pair is sent again, rescaled with the current volumes, and `underrun_o` is high for that frame. `underrun_o` clears at the first boundary that takes a fresh pair.
- R11: `fmt_i`, `wlen_i`, `ratio_i`, both volumes and `mute_i` matter only in the boundary cycle. Changes at any other time do not alter the frame in progress.
- R12: While `rst_ni` is low, `mclk_o`, `bclk_o`, `ws_o`, `sdata_o` and `underrun_o` are low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample pair offered |
| in_ready_o | output | 1 | Holding register empty |
| in_left_i | input | 24 | Left sample, two's complement |
| in_right_i | input | 24 | Right sample, two's complement |
| fmt_i | input | 1 | 0 = I2S, 1 = right-justified |
| wlen_i | input | 2 | Word length code (16/18/20/22) |
| ratio_i | input | 1 | 0 = 256×fs, 1 = 384×fs master clock |
| vol_left_i | input | 8 | Left volume factor |
| vol_right_i | input | 8 | Right volume factor |
| mute_i | input | 1 | Force zero output |
| err_i | input | 1 | Upstream error flag, mutes next frame |
| mclk_o | output | 1 | DAC master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, low = left |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | Current frame repeats the previous pair |

## Verification
The hardest situations to reach from the ports involve events that land exactly on a frame boundary. Examples are an error pulse that ends a frame, a configuration change made partway through a frame, and a second pair offered while the first is still waiting. The bench keeps a behavioural frame counter in step with the design, so it knows which cycle closes each frame. It uses that counter to place error pulses, to change the framing and clock ratio mid-frame, and to hold a second pair on the handshake across a boundary. A cycle-accurate model then predicts every bit of the resulting frames.

// File: rtl/atx_pkg.sv
package atx_pkg;

    typedef enum logic [1:0] {
        WL_16 = 2'd0,
        WL_18 = 2'd1,
        WL_20 = 2'd2,
        WL_22 = 2'd3
    } wlen_e;

    typedef struct packed {
        logic  rjust;
        wlen_e wlen;
        logic  mclk384;
    } fcfg_t;

    localparam int HALF_SLOTS = 32;

    function automatic int unsigned wlen_bits(wlen_e w);
        return 16 + 2 * int'(w);
    endfunction

endpackage

// File: rtl/atx_clock_gen.sv
module atx_clock_gen #(
    parameter int HALF_DIV = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       mclk384_i,
    output logic       mclk_o,
    output logic       bclk_o,
    output logic       ws_o,
    output logic [5:0] slot_nx_o,
    output logic       wrap_o
);
    localparam int SUB_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [3:0]       mh;
        logic [5:0]       slot;
        logic             mclk;
        logic             bclk;
        logic             ws;
    } tstate_t;

    tstate_t s_d, s_q;
    logic [3:0] halves;
    logic       sub_last, mh_last;

    always_comb begin
        halves   = mclk384_i ? 4'd12 : 4'd8;
        sub_last = (s_q.sub == SUB_W'(HALF_DIV - 1));
        mh_last  = (s_q.mh == halves - 4'd1);
        wrap_o   = sub_last && mh_last && (s_q.slot == 6'd63);
        s_d      = s_q;
        if (sub_last) begin
            s_d.sub = '0;
            if (mh_last) begin
                s_d.mh   = 4'd0;
                s_d.slot = s_q.slot + 6'd1;
            end else begin
                s_d.mh = s_q.mh + 4'd1;
            end
        end else begin
            s_d.sub = s_q.sub + 1'b1;
        end
        s_d.mclk = s_d.mh[0];
        s_d.bclk = (s_d.mh >= (halves >> 1));
        s_d.ws   = s_d.slot[5];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign mclk_o    = s_q.mclk;
    assign bclk_o    = s_q.bclk;
    assign ws_o      = s_q.ws;
    assign slot_nx_o = s_d.slot;

    // R2: word select moves only on a falling bit clock
    p_ws_on_bclk_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ws_o) |-> $fell(bclk_o));

    // R1: the bit clock rises on a falling master clock
    p_bclk_rise_on_mclk_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bclk_o) |-> $fell(mclk_o));

endmodule

// File: rtl/atx_sample_hold.sv
module atx_sample_hold
    import atx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int VOL_W    = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wrap_i,
    input  logic                in_valid_i,
    output logic                in_ready_o,
    input  logic [SAMPLE_W-1:0] in_left_i,
    input  logic [SAMPLE_W-1:0] in_right_i,
    input  fcfg_t               cfg_i,
    input  logic [VOL_W-1:0]    vol_l_i,
    input  logic [VOL_W-1:0]    vol_r_i,
    input  logic                mute_i,
    input  logic                err_i,
    output fcfg_t               cfg_o,
    output logic [SAMPLE_W-1:0] word_l_o,
    output logic [SAMPLE_W-1:0] word_r_o,
    output logic                underrun_o
);
    localparam int PROD_W = SAMPLE_W + VOL_W;

    typedef struct packed {
        logic [SAMPLE_W-1:0] hold_l;
        logic [SAMPLE_W-1:0] hold_r;
        logic [SAMPLE_W-1:0] act_l;
        logic [SAMPLE_W-1:0] act_r;
        logic [SAMPLE_W-1:0] word_l;
        logic [SAMPLE_W-1:0] word_r;
        logic                full;
        logic                under;
        logic                err_seen;
        fcfg_t               cfg;
    } hstate_t;

    hstate_t h_d, h_q;
    logic    silence;

    function automatic logic [SAMPLE_W-1:0] scale_cut(
        input logic signed [SAMPLE_W-1:0] smp,
        input logic [VOL_W-1:0]           vol,
        input wlen_e                      wl
    );
        logic signed [PROD_W-1:0] prod;
        logic [SAMPLE_W-1:0]      lvl;
        prod = smp * $signed({1'b0, vol});
        lvl  = SAMPLE_W'(prod >>> VOL_W);
        return lvl >> (SAMPLE_W - int'(wlen_bits(wl)));
    endfunction

    always_comb begin
        in_ready_o = !h_q.full;
        silence    = mute_i || err_i || h_q.err_seen;
        h_d        = h_q;
        if (wrap_i) begin
            h_d.cfg      = cfg_i;
            h_d.err_seen = 1'b0;
            if (h_q.full) begin
                h_d.act_l = h_q.hold_l;
                h_d.act_r = h_q.hold_r;
                h_d.full  = 1'b0;
                h_d.under = 1'b0;
            end else begin
                h_d.under = 1'b1;
            end
            if (silence) begin
                h_d.word_l = '0;
                h_d.word_r = '0;
            end else begin
                h_d.word_l = scale_cut(h_d.act_l, vol_l_i, cfg_i.wlen);
                h_d.word_r = scale_cut(h_d.act_r, vol_r_i, cfg_i.wlen);
            end
        end else begin
            h_d.err_seen = h_q.err_seen || err_i;
        end
        if (in_valid_i && !h_q.full) begin
            h_d.hold_l = in_left_i;
            h_d.hold_r = in_right_i;
            h_d.full   = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) h_q <= '0;
        else         h_q <= h_d;
    end

    assign cfg_o      = h_q.cfg;
    assign word_l_o   = h_q.word_l;
    assign word_r_o   = h_q.word_r;
    assign underrun_o = h_q.under;

    // R7: muted boundary yields silent words
    p_mute_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i && mute_i |=> (word_l_o == '0) && (word_r_o == '0));

    // R8: an error on the boundary cycle silences the next frame
    p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i && err_i |=> (word_l_o == '0) && (word_r_o == '0));

    // R9: a capture outside a boundary closes the handshake
    p_capture_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && in_ready_o && !wrap_i |=> !in_ready_o);

    // R10: underrun flag moves only at frame boundaries
    p_underrun_at_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(underrun_o) |-> $past(wrap_i));

    // R11: frame settings move only at frame boundaries
    p_cfg_at_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cfg_o) |-> $past(wrap_i));

endmodule

// File: rtl/atx_serializer.sv
module atx_serializer
    import atx_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [5:0]          slot_nx_i,
    input  logic                rjust_i,
    input  wlen_e               wlen_i,
    input  logic [SAMPLE_W-1:0] word_l_i,
    input  logic [SAMPLE_W-1:0] word_r_i,
    output logic                sd_o
);
    typedef struct packed {
        logic sd;
    } sstate_t;

    sstate_t             s_d, s_q;
    logic [4:0]          k;
    logic [5:0]          kx, w, idx;
    logic                live;
    logic [SAMPLE_W-1:0] word;

    always_comb begin
        k    = slot_nx_i[4:0];
        kx   = {1'b0, k};
        w    = 6'(wlen_bits(wlen_i));
        word = slot_nx_i[5] ? word_r_i : word_l_i;
        if (rjust_i) begin
            live = (kx >= (6'(HALF_SLOTS) - w));
            idx  = 6'(HALF_SLOTS - 1) - kx;
        end else begin
            live = (k != 5'd0) && (kx <= w);
            idx  = w - kx;
        end
        s_d.sd = live && (|(word & (SAMPLE_W'(1) << idx)));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sd_o = s_q.sd;

    // R3 / R4: the first slot of each half never carries data
    p_slot0_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_nx_i[4:0] == 5'd0) |=> !sd_o);

    // R3: in I2S framing, slots past the word are low
    p_i2s_tail_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rjust_i && ({1'b0, slot_nx_i[4:0]} > 6'(wlen_bits(wlen_i))) |=> !sd_o);

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
    import atx_pkg::*;
#(
    parameter int SAMPLE_W      = 24,
    parameter int VOL_W         = 8,
    parameter int MCLK_HALF_DIV = 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                in_valid_i,
    output logic                in_ready_o,
    input  logic [SAMPLE_W-1:0] in_left_i,
    input  logic [SAMPLE_W-1:0] in_right_i,
    input  logic                fmt_i,
    input  logic [1:0]          wlen_i,
    input  logic                ratio_i,
    input  logic [VOL_W-1:0]    vol_left_i,
    input  logic [VOL_W-1:0]    vol_right_i,
    input  logic                mute_i,
    input  logic                err_i,
    output logic                mclk_o,
    output logic                bclk_o,
    output logic                ws_o,
    output logic                sdata_o,
    output logic                underrun_o
);
    fcfg_t               cfg_in, cfg_q;
    logic [5:0]          slot_nx;
    logic                wrap;
    logic [SAMPLE_W-1:0] word_l, word_r;

    always_comb begin
        cfg_in.rjust   = fmt_i;
        cfg_in.wlen    = wlen_e'(wlen_i);
        cfg_in.mclk384 = ratio_i;
    end

    atx_clock_gen #(
        .HALF_DIV (MCLK_HALF_DIV)
    ) u_clock (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mclk384_i (cfg_q.mclk384),
        .mclk_o    (mclk_o),
        .bclk_o    (bclk_o),
        .ws_o      (ws_o),
        .slot_nx_o (slot_nx),
        .wrap_o    (wrap)
    );

    atx_sample_hold #(
        .SAMPLE_W (SAMPLE_W),
        .VOL_W    (VOL_W)
    ) u_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wrap_i     (wrap),
        .in_valid_i (in_valid_i),
        .in_ready_o (in_ready_o),
        .in_left_i  (in_left_i),
        .in_right_i (in_right_i),
        .cfg_i      (cfg_in),
        .vol_l_i    (vol_left_i),
        .vol_r_i    (vol_right_i),
        .mute_i     (mute_i),
        .err_i      (err_i),
        .cfg_o      (cfg_q),
        .word_l_o   (word_l),
        .word_r_o   (word_r),
        .underrun_o (underrun_o)
    );

    atx_serializer #(
        .SAMPLE_W (SAMPLE_W)
    ) u_ser (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .slot_nx_i (slot_nx),
        .rjust_i   (cfg_q.rjust),
        .wlen_i    (cfg_q.wlen),
        .word_l_i  (word_l),
        .word_r_i  (word_r),
        .sd_o      (sdata_o)
    );

    // R2: serial data moves only on a falling bit clock
    p_sd_on_bclk_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sdata_o) |-> $fell(bclk_o));

    // R12: reset state of the outputs
    always_comb begin
        if (!rst_ni) begin
            p_reset_state_r12: assert (!ws_o && !sdata_o && !underrun_o && in_ready_o);
        end
    end

endmodule

// File: tb/audio_serial_tx_bench.sv
module audio_serial_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 1;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_left = '0, in_right = '0;
    logic        fmt = 1'b0, ratio = 1'b0, mute = 1'b0, err = 1'b0;
    logic [1:0]  wlen = 2'd0;
    logic [7:0]  vol_l = 8'd0, vol_r = 8'd0;
    logic        mclk, bclk, ws, sdata, underrun;

    int checks = 0, errors = 0, cyc = 0;

    // reference model state
    int m_c = 0, m_R = 4, m_flen = 64 * 8 * DIV, m_fmt = 0, m_w = 16;
    int hold_l = 0, hold_r = 0, act_l = 0, act_r = 0, word_l = 0, word_r = 0;
    bit m_full = 0, m_under = 0, m_err_seen = 0, m_acc = 0;
    string tag_cur = "R3", tag_next = "R3";

    always #(CLK_PERIOD / 2) clk = ~clk;

    audio_serial_tx u_audio_serial_tx (
        .clk_i (clk), .rst_ni (rst_n),
        .in_valid_i (in_valid), .in_ready_o (in_ready),
        .in_left_i (in_left), .in_right_i (in_right),
        .fmt_i (fmt), .wlen_i (wlen), .ratio_i (ratio),
        .vol_left_i (vol_l), .vol_right_i (vol_r),
        .mute_i (mute), .err_i (err),
        .mclk_o (mclk), .bclk_o (bclk), .ws_o (ws),
        .sdata_o (sdata), .underrun_o (underrun)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    function automatic int scale(int s, int v, int w);
        longint p  = longint'(s) * longint'(v);
        longint sc = p >>> 8;
        int     u  = int'(sc & 64'hFFFFFF);
        return u >> (24 - w);
    endfunction

    function automatic int exp_bit();
        int mh   = (m_c / DIV) % (2 * m_R);
        int slot = m_c / (DIV * 2 * m_R);
        int k    = slot % 32;
        int wd   = (slot >= 32) ? word_r : word_l;
        if (m_fmt == 0)
            return (k >= 1 && k <= m_w) ? ((wd >> (m_w - k)) & 1) : 0;
        return (k >= 32 - m_w) ? ((wd >> (31 - k)) & 1) : 0;
        mh = mh;
    endfunction

    task automatic model_edge();
        bit acc  = in_valid && !m_full;
        bit dead;
        m_acc = acc;
        if (m_c == m_flen - 1) begin
            m_c    = 0;
            m_fmt  = fmt;
            m_w    = 16 + 2 * int'(wlen);
            m_R    = ratio ? 6 : 4;
            m_flen = 64 * 2 * m_R * DIV;
            dead   = mute || err || m_err_seen;
            m_err_seen = 0;
            if (m_full) begin
                act_l = hold_l; act_r = hold_r; m_full = 0; m_under = 0;
            end else begin
                m_under = 1;
            end
            word_l  = dead ? 0 : scale(act_l, int'(vol_l), m_w);
            word_r  = dead ? 0 : scale(act_r, int'(vol_r), m_w);
            tag_cur = tag_next;
        end else begin
            m_c++;
            m_err_seen = m_err_seen || err;
        end
        if (acc) begin
            hold_l = int'($signed(in_left));
            hold_r = int'($signed(in_right));
            m_full = 1;
        end
    endtask

    task automatic step();
        int mh, slot;
        @(posedge clk);
        model_edge();
        #1;
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
            finish_run();
        end
        mh   = (m_c / DIV) % (2 * m_R);
        slot = m_c / (DIV * 2 * m_R);
        chk("R1", "mclk", int'(mclk), mh % 2);
        chk("R1", "bclk", int'(bclk), (mh >= m_R) ? 1 : 0);
        chk("R2", "ws", int'(ws), (slot >= 32) ? 1 : 0);
        chk(tag_cur, "sdata", int'(sdata), exp_bit());
        chk("R9", "in_ready", int'(in_ready), m_full ? 0 : 1);
        chk("R10", "underrun", int'(underrun), int'(m_under));
    endtask

    task automatic wait_wrap();
        do step(); while (m_c != 0);
    endtask

    task automatic push_pair(int l, int r);
        in_valid = 1'b1;
        in_left  = 24'(l);
        in_right = 24'(r);
        do step(); while (!m_acc);
        in_valid = 1'b0;
    endtask

    task automatic set_cfg(bit f, int wl, bit rt, int vl, int vr, bit mu);
        fmt = f; wlen = 2'(wl); ratio = rt;
        vol_l = 8'(vl); vol_r = 8'(vr); mute = mu;
    endtask

    task automatic run_frame(string tag, bit f, int wl, bit rt, int vl, int vr,
                             bit mu, bit do_push, int l, int r, bit errp);
        tag_next = tag;
        set_cfg(f, wl, rt, vl, vr, mu);
        if (do_push) push_pair(l, r);
        if (errp) begin
            repeat (50) step();
            err = 1'b1;
            step();
            err = 1'b0;
        end
        wait_wrap();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12", "mclk in reset", int'(mclk), 0);
        chk("R12", "bclk in reset", int'(bclk), 0);
        chk("R12", "ws in reset", int'(ws), 0);
        chk("R12", "sdata in reset", int'(sdata), 0);
        chk("R12", "underrun in reset", int'(underrun), 0);
        chk("R12", "in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;

        // R3: I2S, 16-bit
        run_frame("R3", 0, 0, 0, 128, 200, 0, 1, 24'h123456, -24'h234567, 0);
        run_frame("R3", 0, 0, 0, 255, 255, 0, 1, -1, 24'h7FFFFF, 0);
        // R5: other word lengths
        run_frame("R5", 0, 1, 0, 255, 77, 0, 1, -24'h3A5C71, 24'h55AA33, 0);
        run_frame("R5", 0, 2, 0, 99, 255, 0, 1, 24'h6DB6DB, -24'h12345, 0);
        run_frame("R5", 0, 3, 0, 255, 180, 0, 1, -24'h7FFFFF, 24'h2AAAAA, 0);
        // R4: right-justified
        run_frame("R4", 1, 0, 0, 255, 255, 0, 1, 24'h4C3B2A, -24'h1F0F0F, 0);
        run_frame("R4", 1, 3, 0, 140, 255, 0, 1, -24'h5EDCBA, 24'h7ABCDE, 0);
        // R1: 384 x fs master clock
        run_frame("R1", 0, 2, 1, 255, 255, 0, 1, 24'h3F00FF, -24'h400001, 0);
        run_frame("R1", 1, 1, 1, 201, 33, 0, 1, -24'h0F0F0F, 24'h70F0F0, 0);
        // R6: volume extremes
        run_frame("R6", 0, 3, 0, 0, 1, 0, 1, -24'h800000, 24'h7FFFFF, 0);
        run_frame("R6", 0, 3, 0, 255, 254, 0, 1, -3, -24'h800000, 0);
        // R7: mute then release
        run_frame("R7", 0, 0, 0, 255, 255, 1, 1, 24'h7FFFFF, -24'h7FFFFF, 0);
        run_frame("R7", 0, 0, 0, 255, 255, 0, 1, 24'h7FFFFF, -24'h7FFFFF, 0);
        // R8: error pulse mid-frame, then recovery
        run_frame("R8", 1, 2, 0, 255, 255, 0, 1, 24'h1234AB, 24'h6543CD, 1);
        run_frame("R8", 1, 2, 0, 255, 255, 0, 1, 24'h1234AB, 24'h6543CD, 0);
        // R8: error on the boundary cycle itself
        tag_next = "R8";
        push_pair(24'h3C3C3C, -24'h3C3C3C);
        while (m_c != m_flen - 1) step();
        err = 1'b1;
        step();
        err = 1'b0;
        run_frame("R8", 0, 1, 0, 255, 255, 0, 1, 24'h3C3C3C, -24'h3C3C3C, 0);
        // R10: underrun, repeat with new volume, then fresh data
        run_frame("R10", 0, 0, 0, 255, 255, 0, 0, 0, 0, 0);
        run_frame("R10", 0, 0, 0, 60, 190, 0, 0, 0, 0, 0);
        run_frame("R10", 0, 0, 0, 255, 255, 0, 1, -24'h222222, 24'h333333, 0);
        // R11: settings moved partway through a frame
        tag_next = "R11";
        set_cfg(0, 0, 0, 255, 255, 0);
        push_pair(24'h5A5A5A, -24'h5A5A5A);
        repeat (200) step();
        set_cfg(1, 3, 1, 90, 170, 0);
        wait_wrap();
        run_frame("R11", 0, 1, 0, 255, 255, 0, 1, 24'h0FF0F0, 24'h70000F, 0);
        // R9: second pair held on the handshake across a boundary
        tag_next = "R9";
        set_cfg(0, 2, 0, 255, 255, 0);
        push_pair(24'h111111, 24'h222222);
        push_pair(-24'h444444, 24'h555555);
        wait_wrap();
        run_frame("R9", 0, 2, 0, 255, 255, 0, 0, 0, 0, 0);
        repeat (20) step();
        finish_run();
    end
endmodule